// File: doc/BRIEF.md
# Operand bypass and load-use interlock

This block watches the register numbers flowing through a five-stage, in-order integer pipeline and settles read-after-write conflicts without software help. For each of the two ALU operands of the instruction in the execute stage, it chooses where the value comes from. The choices are the value read from the register file, the ALU result held after execute, or the value about to be written back. When two older instructions both write the register, the younger writer wins.

A value fetched from memory is not ready early enough to reach the instruction directly behind the load. In that case the block holds the program counter and the fetch/decode register for one cycle and asks for a bubble, so the execute stage receives all-zero controls. The register file writes early in a cycle and reads late in it. A reader three slots behind its producer therefore needs no help from this block.

The block is purely combinational. It sits between the pipeline registers and the operand multiplexers.

Top module: `hazard_resolver`

## Requirements
- R1: An operand select is 2'b00 (register file) when neither the post-execute stage nor the write-back stage will write the operand's source register.
- R2: An operand select is 2'b10 (post-execute ALU result) when `mem_reg_write`=1 and `mem_rd` equals that operand's source register.
- R3: An operand select is 2'b01 (write-back value) when `wb_reg_write`=1 and `wb_rd` equals the source register, and the post-execute stage does not match.
- R4: When both later stages would supply the same source register, the select is 2'b10, because the post-execute value is the newer one.
- R5: Register 0 is never bypassed. A source of 0 always yields select 2'b00, even when a stage writes register 0.
- R6: A stage whose write flag is 0 is never used as a bypass source, even when its destination matches.
- R7: `fwd_a` follows only `ex_rs1` and `fwd_b` follows only `ex_rs2`. Each is worked out independently of the other.
- R8: When `ex_mem_read`=1, `ex_rd`≠0, and `ex_rd` equals `id_rs1` or `id_rs2`, `bubble_req` is 1 and `front_write_en` is 0.
- R9: No stall is raised when `ex_mem_read`=0, when `ex_rd`=0, or when neither decode source equals `ex_rd`. In those cases `bubble_req` is 0 and `front_write_en` is 1.
- R10: `front_write_en` is always the inverse of `bubble_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RA_W | First source register of the decode-stage instruction |
| id_rs2 | input | RA_W | Second source register of the decode-stage instruction |
| ex_rs1 | input | RA_W | First source register of the execute-stage instruction |
| ex_rs2 | input | RA_W | Second source register of the execute-stage instruction |
| ex_rd | input | RA_W | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RA_W | Destination register held after execute |
| mem_reg_write | input | 1 | Post-execute instruction writes a register |
| wb_rd | input | RA_W | Destination register in write-back |
| wb_reg_write | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| front_write_en | output | 1 | Enables update of the PC and fetch/decode register |
| bubble_req | output | 1 | Request zero controls into the execute-stage register |

## Verification
The assertions check every cycle that each select agrees with the match conditions. That covers priority of the newer stage, the register-0 exclusion and the write-flag gate. They also check that the stall output rises exactly when a load in execute feeds a decode source.

Other behaviours appear only in the bench's scenarios. One is the independence of the two operands. Another is the complement relation between the two stall outputs. The third is the handling of mixed patterns in which a load-use stall coincides with active bypassing.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwd_sel_e;

  localparam int NUM_OPERANDS = 2;
endpackage

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] src,
  input  logic [RA_W-1:0] mem_rd,
  input  logic            mem_we,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_we,
  output logic [1:0]      sel
);
  import hazard_pkg::*;

  function automatic logic stage_hit(input logic [RA_W-1:0] dst,
                                     input logic            we,
                                     input logic [RA_W-1:0] s);
    return we && (dst != '0) && (dst == s);
  endfunction

  logic mem_hit;
  logic wb_hit;
  fwd_sel_e choice;

  assign mem_hit = stage_hit(mem_rd, mem_we, src);
  assign wb_hit  = stage_hit(wb_rd, wb_we, src);

  always_comb begin
    if (mem_hit)      choice = SEL_MEM;
    else if (wb_hit)  choice = SEL_WB;
    else              choice = SEL_REGFILE;
  end

  assign sel = choice;
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_load,
  input  logic [RA_W-1:0] dec_src0,
  input  logic [RA_W-1:0] dec_src1,
  output logic            stall
);
  function automatic logic load_feeds(input logic [RA_W-1:0] dst,
                                      input logic            ld,
                                      input logic [RA_W-1:0] s);
    return ld && (dst != '0) && (dst == s);
  endfunction

  logic feeds_src0;
  logic feeds_src1;

  assign feeds_src0 = load_feeds(ex_rd, ex_load, dec_src0);
  assign feeds_src1 = load_feeds(ex_rd, ex_load, dec_src1);
  assign stall      = feeds_src0 | feeds_src1;
endmodule

// File: rtl/hazard_resolver.sv
module hazard_resolver #(
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] id_rs1,
  input  logic [RA_W-1:0] id_rs2,
  input  logic [RA_W-1:0] ex_rs1,
  input  logic [RA_W-1:0] ex_rs2,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_mem_read,
  input  logic [RA_W-1:0] mem_rd,
  input  logic            mem_reg_write,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_reg_write,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            front_write_en,
  output logic            bubble_req
);
  import hazard_pkg::*;

  logic [RA_W-1:0] op_src [NUM_OPERANDS];
  logic [1:0]      op_sel [NUM_OPERANDS];
  logic            load_use_stall;

  assign op_src[0] = ex_rs1;
  assign op_src[1] = ex_rs2;

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
    operand_bypass #(.RA_W(RA_W)) u_bypass (
      .src    (op_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_reg_write),
      .wb_rd  (wb_rd),
      .wb_we  (wb_reg_write),
      .sel    (op_sel[g])
    );
  end

  load_use_detect #(.RA_W(RA_W)) u_lu (
    .ex_rd    (ex_rd),
    .ex_load  (ex_mem_read),
    .dec_src0 (id_rs1),
    .dec_src1 (id_rs2),
    .stall    (load_use_stall)
  );

  assign fwd_a          = op_sel[0];
  assign fwd_b          = op_sel[1];
  assign bubble_req     = load_use_stall;
  assign front_write_en = ~load_use_stall;
endmodule

// File: rtl/hazard_resolver_chk.sv
module hazard_resolver_chk #(
  parameter int RA_W = 5
) (
  input logic [RA_W-1:0] id_rs1,
  input logic [RA_W-1:0] id_rs2,
  input logic [RA_W-1:0] ex_rs1,
  input logic [RA_W-1:0] ex_rs2,
  input logic [RA_W-1:0] ex_rd,
  input logic            ex_mem_read,
  input logic [RA_W-1:0] mem_rd,
  input logic            mem_reg_write,
  input logic [RA_W-1:0] wb_rd,
  input logic            wb_reg_write,
  input logic [1:0]      fwd_a,
  input logic [1:0]      fwd_b,
  input logic            bubble_req
);
  logic mem_for_a;
  logic mem_for_b;
  logic load_conflict;

  assign mem_for_a = mem_reg_write && (mem_rd != '0) && (mem_rd == ex_rs1);
  assign mem_for_b = mem_reg_write && (mem_rd != '0) && (mem_rd == ex_rs2);
  assign load_conflict = ex_mem_read && (ex_rd != '0) &&
                         ((ex_rd == id_rs1) || (ex_rd == id_rs2));

  always_comb begin
    // R2 and R4: a matching post-execute writer always wins
    a_r2_mem_wins_a: assert (!mem_for_a || fwd_a == 2'b10);
    a_r4_mem_wins_b: assert (!mem_for_b || fwd_b == 2'b10);
    // R5: register 0 is never bypassed
    a_r5_zero_src: assert (ex_rs1 != '0 || fwd_a == 2'b00);
    // R6: with no writers there is nothing to bypass
    a_r6_no_writers: assert ((mem_reg_write || wb_reg_write) ||
                             (fwd_a == 2'b00 && fwd_b == 2'b00));
    // R3: the write-back select only when that stage matches
    a_r3_wb_needs_match: assert (fwd_a != 2'b01 ||
                                 (wb_reg_write && wb_rd == ex_rs1 && !mem_for_a));
    // R8 and R9: stall exactly on a load feeding decode
    a_r8_stall_match: assert (bubble_req == load_conflict);
  end
endmodule

bind hazard_resolver hazard_resolver_chk #(.RA_W(RA_W)) u_chk (
  .id_rs1        (id_rs1),
  .id_rs2        (id_rs2),
  .ex_rs1        (ex_rs1),
  .ex_rs2        (ex_rs2),
  .ex_rd         (ex_rd),
  .ex_mem_read   (ex_mem_read),
  .mem_rd        (mem_rd),
  .mem_reg_write (mem_reg_write),
  .wb_rd         (wb_rd),
  .wb_reg_write  (wb_reg_write),
  .fwd_a         (fwd_a),
  .fwd_b         (fwd_b),
  .bubble_req    (bubble_req)
);

// File: tb/hazard_resolver_tb.sv
module hazard_resolver_tb;
  localparam int RA_W = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RA_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_mem_read, mem_reg_write, wb_reg_write;
  logic [1:0] fwd_a, fwd_b;
  logic front_write_en, bubble_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  hazard_resolver #(.RA_W(RA_W)) u_dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_mem_read(ex_mem_read), .mem_rd(mem_rd),
    .mem_reg_write(mem_reg_write), .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .front_write_en(front_write_en),
    .bubble_req(bubble_req)
  );

  function automatic logic [1:0] want_sel(input logic [RA_W-1:0] s,
      input logic [RA_W-1:0] m, input logic mw,
      input logic [RA_W-1:0] w, input logic ww);
    if (s == 0) return 2'b00;
    if (mw && m == s) return 2'b10;
    if (ww && w == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic want_stall(input logic ld, input logic [RA_W-1:0] d,
      input logic [RA_W-1:0] a, input logic [RA_W-1:0] b);
    return ld && d != 0 && (d == a || d == b);
  endfunction

  function automatic string sel_tag(input logic [1:0] v, input logic both);
    if (both) return "R4";
    if (v == 2'b10) return "R2";
    if (v == 2'b01) return "R3";
    return "R1";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [RA_W-1:0] i1, i2, e1, e2, erd,
                       input logic eld, input logic [RA_W-1:0] mrd,
                       input logic mw, input logic [RA_W-1:0] wrd, input logic ww);
    @(posedge clk);
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
    ex_mem_read = eld; mem_rd = mrd; mem_reg_write = mw;
    wb_rd = wrd; wb_reg_write = ww;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    logic st;
    ea = want_sel(ex_rs1, mem_rd, mem_reg_write, wb_rd, wb_reg_write);
    eb = want_sel(ex_rs2, mem_rd, mem_reg_write, wb_rd, wb_reg_write);
    st = want_stall(ex_mem_read, ex_rd, id_rs1, id_rs2);
    check({tag, " fwd_a"}, fwd_a, ea);
    check({tag, " fwd_b"}, fwd_b, eb);
    check({tag, " bubble R8"}, bubble_req, st);
    check({tag, " front R10"}, front_write_en, !st);
  endtask

  initial begin
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_mem_read = 0; mem_reg_write = 0; wb_reg_write = 0;
    void'($urandom(32'd7319));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: R1, R9
    check("R1 idle fwd_a", fwd_a, 0);
    check("R1 idle fwd_b", fwd_b, 0);
    check("R9 idle bubble", bubble_req, 0);
    check("R10 idle front", front_write_en, 1);
    // R2: post-execute match on A only (R7)
    drive(0, 0, 3, 4, 0, 0, 3, 1, 0, 0);
    check("R2 fwd_a", fwd_a, 2); check("R7 fwd_b", fwd_b, 0);
    // R3: write-back match on B only
    drive(0, 0, 5, 6, 0, 0, 0, 0, 6, 1);
    check("R3 fwd_b", fwd_b, 1); check("R7 fwd_a", fwd_a, 0);
    // R4: both match, newer wins
    drive(0, 0, 9, 9, 0, 0, 9, 1, 9, 1);
    check("R4 fwd_a", fwd_a, 2); check("R4 fwd_b", fwd_b, 2);
    // R5: register 0 never bypassed
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    check("R5 fwd_a", fwd_a, 0); check("R5 fwd_b", fwd_b, 0);
    // R6: write flag low blocks bypass
    drive(0, 0, 7, 7, 0, 0, 7, 0, 7, 0);
    check("R6 fwd_a", fwd_a, 0); check("R6 fwd_b", fwd_b, 0);
    drive(0, 0, 7, 8, 0, 0, 7, 0, 7, 1);
    check("R6 fall to wb", fwd_a, 1);
    // R8: load feeding decode source 1, then source 2
    drive(12, 1, 0, 0, 12, 1, 0, 0, 0, 0);
    check("R8 bubble rs1", bubble_req, 1); check("R8 front rs1", front_write_en, 0);
    drive(2, 13, 0, 0, 13, 1, 0, 0, 0, 0);
    check("R8 bubble rs2", bubble_req, 1); check("R10 front rs2", front_write_en, 0);
    // R9: no load, zero destination, no match
    drive(12, 1, 0, 0, 12, 0, 0, 0, 0, 0);
    check("R9 no load", bubble_req, 0);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    check("R9 rd zero", bubble_req, 0); check("R10 rd zero", front_write_en, 1);
    drive(3, 4, 0, 0, 5, 1, 0, 0, 0, 0);
    check("R9 no match", bubble_req, 0);
    // random mix over a small register range to provoke matches
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ea;
      drive($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3),
            $urandom_range(3), 1'($urandom), $urandom_range(3), 1'($urandom),
            $urandom_range(3), 1'($urandom));
      ea = want_sel(ex_rs1, mem_rd, mem_reg_write, wb_rd, wb_reg_write);
      check_all(sel_tag(ea, ex_rs1 != 0 && mem_reg_write && wb_reg_write &&
                        mem_rd == ex_rs1 && wb_rd == ex_rs1));
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule